// File: doc/BRIEF.md
# Two-Wire Control Register Write Decoder

This block listens to a two-wire serial bus as a slave and decodes only write transactions. It detects start and stop conditions and shifts in three bytes: a slave byte, an address byte and one data byte. It acknowledges the bytes it accepts by pulling the data line low. Two classes of slave byte are recognised. The first class reaches a small control register that holds the watchdog period field and two write-enable latches. The second class reaches a pair of threshold-programming addresses.

Nothing takes effect while the bytes arrive. The decoder acts only on a stop condition that closes a complete transaction. The control register needs an unlock sequence before its period field can change, and a write-protect pin can freeze that field. Threshold requests are honoured only while a digital flag reports that the programming voltage is present.

The serial lines, the write-protect pin and the voltage flag are plain pins, already synchronised to `clk`. The block has no streaming data path, so no valid/ready handshake is used. All outputs are registered. The data-line pull-down (`sda_low_o`) is meant to drive an open-drain pad.

Top module: `tw_wr_decoder`

## Requirements
- R1: A slave byte is acknowledged when its upper four bits are 1011b or when it equals A0h exactly. Any other slave byte gets no acknowledge, and the rest of that transaction has no effect.
- R2: Bytes are taken MSB first on SCL rising edges. `sda_low_o` goes high at the SCL fall that ends the eighth bit and drops at the SCL fall that ends the ninth clock. It is low at every other time.
- R3: The 9-bit address is {slave byte bit 0, address byte}. Only 1FFh under a 1011b slave byte reaches the control register. Writes to any other address leave the register unchanged.
- R4: Data 02h sets the first enable latch (`wel_o`) and clears the second (`rwel_o`). Data 06h sets `rwel_o` only while `wel_o` is already set. `rwel_o` is never high while `wel_o` is low.
- R5: With both latches set, any data byte other than 02h or 06h is a store. The store loads data bits [7:6] into `wd_o` and clears both latches. When the latches are not both set, a data byte other than 02h or 06h clears both latches.
- R6: While `wp_i` is high at the stop, a store leaves `wd_o` unchanged and gives no `commit_o` pulse, but it still clears both latches. A store with `wp_i` low pulses `commit_o`.
- R7: Only the first data byte of a transaction is acknowledged. Later data bytes are not acknowledged and are discarded. The first byte is still committed at the stop.
- R8: Nothing changes before the stop. A repeated start discards the pending write.
- R9: A start or stop that arrives after two or more bits of a byte have been shifted aborts the transaction, and nothing is committed. A stop preceded by at most one SCL rise after a byte boundary is valid.
- R10: A write with slave A0h, 9-bit address 001h and data 00h, closed by a stop while `hv_i` is high, gives one `vset_o` pulse.
- R11: The same write to address 003h gives one `vclr_o` pulse. Either request is suppressed when `hv_i` is low or when the data is not 00h.
- R12: `commit_o`, `vset_o` and `vclr_o` are pulses exactly one clock wide, in the cycle after the stop is sampled.
- R13: After reset, `wd_o` is 00b, both latches are clear and `sda_low_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| wp_i | input | 1 | Write protect for the period field |
| hv_i | input | 1 | Programming-voltage-present flag |
| sda_low_o | output | 1 | Pull data line low (acknowledge) |
| wd_o | output | 2 | Watchdog period field |
| wel_o | output | 1 | First write-enable latch |
| rwel_o | output | 1 | Second write-enable latch |
| commit_o | output | 1 | Pulse: period field stored |
| vset_o | output | 1 | Pulse: threshold-set request |
| vclr_o | output | 1 | Pulse: threshold-reset request |

## Verification
The hardest state to reach from the pins is an abort in the middle of the third, committing write. In that state both latches are set and a complete data byte is pending, and then the bus breaks off. The stimulus first runs the two unlock writes. It then sends a full store byte and stops the bus after a few bits of a further byte, or issues a repeated start. It checks that the latches and `wd_o` are unchanged at the pins. A sweep of third-write data values under both write-protect levels compares `wd_o`, the latches and the commit pulse count against values computed from the data byte.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // Transaction position within a frame
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_SLAVE,
    FR_ADDR,
    FR_DATA,
    FR_EXTRA,
    FR_SKIP
  } frame_e;

  // Which function the slave byte selected
  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_THR
  } target_e;

  // Bits shifted into a byte at which a start/stop counts as mid-byte
  localparam int unsigned MID_BYTE_BITS = 2;

endpackage

// File: rtl/tw_line_mon.sv
module tw_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // Edges of SCL; bus conditions are SDA edges while SCL stays high
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/tw_byte_rx.sv
module tw_byte_rx #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = $clog2(BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              frame_edge_i,
  input  logic              sda_i,
  input  logic              ack_req_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              ack_low_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_SLOT = CNT_W'(BYTE_W + 1);

  logic [BYTE_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              vld_q;
  logic              ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (frame_edge_i) begin
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (scl_rise_i) begin
        if (cnt_q < CNT_FULL) begin
          shift_q <= {shift_q[BYTE_W-2:0], sda_i};
          cnt_q   <= cnt_q + 1'b1;
          vld_q   <= (cnt_q == CNT_LAST);
        end
      end else if (scl_fall_i) begin
        if (cnt_q == CNT_FULL) begin
          ack_q <= ack_req_i;
          cnt_q <= CNT_SLOT;
        end else if (cnt_q == CNT_SLOT) begin
          ack_q <= 1'b0;
          cnt_q <= '0;
        end
      end
    end
  end

  assign byte_o     = shift_q;
  assign byte_vld_o = vld_q;
  assign bit_cnt_o  = cnt_q;
  assign ack_low_o  = ack_q;

endmodule

// File: rtl/tw_cmd_ctrl.sv
module tw_cmd_ctrl
  import tw_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned WD_W      = 2,
  parameter int unsigned WD_LSB    = 6,
  parameter logic [3:0]  CTRL_NIB  = 4'hB,
  parameter logic [8:0]  CTRL_ADDR = 9'h1FF,
  parameter logic [7:0]  THR_SLAVE = 8'hA0,
  parameter logic [8:0]  SET_ADDR  = 9'h001,
  parameter logic [8:0]  CLR_ADDR  = 9'h003,
  parameter logic [7:0]  WEL_KEY   = 8'h02,
  parameter logic [7:0]  RWEL_KEY  = 8'h06,
  parameter logic [WD_W-1:0] WD_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              wp_i,
  input  logic              hv_i,
  output logic              ack_req_o,
  output logic [WD_W-1:0]   wd_o,
  output logic              wel_o,
  output logic              rwel_o,
  output logic              commit_o,
  output logic              vset_o,
  output logic              vclr_o
);

  localparam int unsigned ADDR_W = BYTE_W + 1;
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(MID_BYTE_BITS);

  frame_e             fr_q;
  target_e            tgt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BYTE_W-1:0]  data_q;
  logic               ack_q;
  logic [WD_W-1:0]    wd_q;
  logic               wel_q;
  logic               rwel_q;
  logic               commit_q;
  logic               vset_q;
  logic               vclr_q;

  logic               mid_byte;
  logic               frame_ok;
  logic               ctrl_hit;
  logic               thr_ok;
  logic               is_wel_key;
  logic               is_rwel_key;

  assign mid_byte    = (bit_cnt_i >= MID_CNT);
  assign frame_ok    = (fr_q == FR_EXTRA) && !mid_byte;
  assign ctrl_hit    = (tgt_q == TGT_CTRL) && (addr_q == CTRL_ADDR);
  assign thr_ok      = (tgt_q == TGT_THR) && (data_q == '0) && hv_i;
  assign is_wel_key  = (data_q == WEL_KEY);
  assign is_rwel_key = (data_q == RWEL_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q     <= FR_IDLE;
      tgt_q    <= TGT_NONE;
      addr_q   <= '0;
      data_q   <= '0;
      ack_q    <= 1'b0;
      wd_q     <= WD_INIT;
      wel_q    <= 1'b0;
      rwel_q   <= 1'b0;
      commit_q <= 1'b0;
      vset_q   <= 1'b0;
      vclr_q   <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      vset_q   <= 1'b0;
      vclr_q   <= 1'b0;
      if (start_i) begin
        fr_q  <= FR_SLAVE;
        tgt_q <= TGT_NONE;
        ack_q <= 1'b0;
      end else if (stop_i) begin
        fr_q  <= FR_IDLE;
        ack_q <= 1'b0;
        if (frame_ok && ctrl_hit) begin
          if (is_wel_key) begin
            wel_q  <= 1'b1;
            rwel_q <= 1'b0;
          end else if (is_rwel_key && wel_q) begin
            rwel_q <= 1'b1;
          end else if (wel_q && rwel_q) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
            if (!wp_i) begin
              wd_q     <= data_q[WD_LSB +: WD_W];
              commit_q <= 1'b1;
            end
          end else begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
          end
        end
        if (frame_ok && thr_ok) begin
          vset_q <= (addr_q == SET_ADDR);
          vclr_q <= (addr_q == CLR_ADDR);
        end
      end else if (byte_vld_i) begin
        unique case (fr_q)
          FR_SLAVE: begin
            addr_q[ADDR_W-1] <= byte_i[0];
            if (byte_i[BYTE_W-1 -: 4] == CTRL_NIB) begin
              tgt_q <= TGT_CTRL;
              ack_q <= 1'b1;
              fr_q  <= FR_ADDR;
            end else if (byte_i == THR_SLAVE) begin
              tgt_q <= TGT_THR;
              ack_q <= 1'b1;
              fr_q  <= FR_ADDR;
            end else begin
              tgt_q <= TGT_NONE;
              ack_q <= 1'b0;
              fr_q  <= FR_SKIP;
            end
          end
          FR_ADDR: begin
            addr_q[BYTE_W-1:0] <= byte_i;
            ack_q              <= 1'b1;
            fr_q               <= FR_DATA;
          end
          FR_DATA: begin
            data_q <= byte_i;
            ack_q  <= 1'b1;
            fr_q   <= FR_EXTRA;
          end
          default: begin
            ack_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign ack_req_o = ack_q;
  assign wd_o      = wd_q;
  assign wel_o     = wel_q;
  assign rwel_o    = rwel_q;
  assign commit_o  = commit_q;
  assign vset_o    = vset_q;
  assign vclr_o    = vclr_q;

endmodule

// File: rtl/tw_wr_decoder.sv
module tw_wr_decoder #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned WD_W      = 2,
  parameter int unsigned WD_LSB    = 6,
  parameter logic [3:0]  CTRL_NIB  = 4'hB,
  parameter logic [8:0]  CTRL_ADDR = 9'h1FF,
  parameter logic [7:0]  THR_SLAVE = 8'hA0,
  parameter logic [8:0]  SET_ADDR  = 9'h001,
  parameter logic [8:0]  CLR_ADDR  = 9'h003,
  parameter logic [7:0]  WEL_KEY   = 8'h02,
  parameter logic [7:0]  RWEL_KEY  = 8'h06,
  parameter logic [WD_W-1:0] WD_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            wp_i,
  input  logic            hv_i,
  output logic            sda_low_o,
  output logic [WD_W-1:0] wd_o,
  output logic            wel_o,
  output logic            rwel_o,
  output logic            commit_o,
  output logic            vset_o,
  output logic            vclr_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 2);

  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_vld;
  logic [CNT_W-1:0]  rx_cnt;
  logic              ack_req;

  tw_line_mon line_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_byte_rx #(
    .BYTE_W (BYTE_W),
    .CNT_W  (CNT_W)
  ) rx_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .frame_edge_i (start_det | stop_det),
    .sda_i        (sda_i),
    .ack_req_i    (ack_req),
    .byte_o       (rx_byte),
    .byte_vld_o   (rx_vld),
    .bit_cnt_o    (rx_cnt),
    .ack_low_o    (sda_low_o)
  );

  tw_cmd_ctrl #(
    .BYTE_W    (BYTE_W),
    .CNT_W     (CNT_W),
    .WD_W      (WD_W),
    .WD_LSB    (WD_LSB),
    .CTRL_NIB  (CTRL_NIB),
    .CTRL_ADDR (CTRL_ADDR),
    .THR_SLAVE (THR_SLAVE),
    .SET_ADDR  (SET_ADDR),
    .CLR_ADDR  (CLR_ADDR),
    .WEL_KEY   (WEL_KEY),
    .RWEL_KEY  (RWEL_KEY),
    .WD_INIT   (WD_INIT)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_i     (rx_byte),
    .byte_vld_i (rx_vld),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .bit_cnt_i  (rx_cnt),
    .wp_i       (wp_i),
    .hv_i       (hv_i),
    .ack_req_o  (ack_req),
    .wd_o       (wd_o),
    .wel_o      (wel_o),
    .rwel_o     (rwel_o),
    .commit_o   (commit_o),
    .vset_o     (vset_o),
    .vclr_o     (vclr_o)
  );

endmodule

// File: rtl/tw_wr_decoder_chk.sv
module tw_wr_decoder_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WD_W   = 2,
  parameter int unsigned CNT_W  = $clog2(BYTE_W + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wp_i,
  input logic            hv_i,
  input logic            sda_low_o,
  input logic [WD_W-1:0] wd_o,
  input logic            wel_o,
  input logic            rwel_o,
  input logic            commit_o,
  input logic            vset_o,
  input logic            vclr_o,
  input logic            stop_det,
  input logic [CNT_W-1:0] rx_cnt
);

  localparam logic [CNT_W-1:0] SLOT = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(2);

  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_o |-> (rx_cnt == SLOT)); // R2

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    rwel_o |-> wel_o); // R4

  AST_STORE_CLEARS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!wel_o && !rwel_o)); // R5

  AST_WP_FREEZES_WD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp_i) |-> $stable(wd_o)); // R6

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o || vset_o || vclr_o) |-> $past(stop_det)); // R8

  AST_MID_BYTE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && (rx_cnt >= MID)) |=> (!commit_o && !vset_o && !vclr_o)); // R9

  AST_REQ_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
    (vset_o || vclr_o) |-> $past(hv_i)); // R10

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o || vset_o || vclr_o) |=> !(commit_o || vset_o || vclr_o)); // R12

endmodule

bind tw_wr_decoder tw_wr_decoder_chk #(
  .BYTE_W (BYTE_W),
  .WD_W   (WD_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_i      (wp_i),
  .hv_i      (hv_i),
  .sda_low_o (sda_low_o),
  .wd_o      (wd_o),
  .wel_o     (wel_o),
  .rwel_o    (rwel_o),
  .commit_o  (commit_o),
  .vset_o    (vset_o),
  .vclr_o    (vclr_o),
  .stop_det  (stop_det),
  .rx_cnt    (rx_cnt)
);

// File: tb/tw_wr_decoder_tb.sv
`timescale 1ns/1ps
module tw_wr_decoder_tb_top;

  localparam int Q = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       wp = 1'b0;
  logic       hv = 1'b0;
  logic       sda_low;
  logic [1:0] wd;
  logic       wel, rwel, commit, vset, vclr;
  logic       sda_line;

  int n_chk = 0;
  int n_err = 0;
  int n_commit = 0;
  int n_vset = 0;
  int n_vclr = 0;
  bit done = 1'b0;

  // Expected state, from the requirements
  logic [1:0] e_wd = 2'b00;
  logic       e_wel = 1'b0;
  logic       e_rwel = 1'b0;
  int         e_commit = 0;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_low;

  tw_wr_decoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .wp_i      (wp),
    .hv_i      (hv),
    .sda_low_o (sda_low),
    .wd_o      (wd),
    .wel_o     (wel),
    .rwel_o    (rwel),
    .commit_o  (commit),
    .vset_o    (vset),
    .vclr_o    (vclr)
  );

  always @(negedge clk) begin
    if (commit) n_commit++;
    if (vset)   n_vset++;
    if (vclr)   n_vclr++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; half();
    m_scl = 1'b1; half();
    m_sda = 1'b0; half();
    m_scl = 1'b0; half();
  endtask

  task automatic bstop();
    m_sda = 1'b0; half();
    m_scl = 1'b1; half();
    m_sda = 1'b1; half(); half();
  endtask

  task automatic sbit(input logic b);
    m_sda = b; half();
    m_scl = 1'b1; half();
    m_scl = 1'b0; half();
  endtask

  task automatic sbyte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    m_sda = 1'b1; half();
    acked = sda_low;
    m_scl = 1'b1; half();
    m_scl = 1'b0; half();
  endtask

  task automatic wr(input logic [7:0] s, input logic [7:0] a, input logic [7:0] d,
                    output logic [2:0] acks);
    logic k;
    bstart();
    sbyte(s, k); acks[2] = k;
    sbyte(a, k); acks[1] = k;
    sbyte(d, k); acks[0] = k;
    bstop();
  endtask

  task automatic model_ctrl(input logic [7:0] d, input logic p);
    if (d == 8'h02) begin e_wel = 1'b1; e_rwel = 1'b0; end
    else if (d == 8'h06 && e_wel) e_rwel = 1'b1;
    else if (e_wel && e_rwel) begin
      e_wel = 1'b0; e_rwel = 1'b0;
      if (!p) begin e_wd = d[7:6]; e_commit++; end
    end else begin e_wel = 1'b0; e_rwel = 1'b0; end
  endtask

  task automatic cmp_state(input string tag);
    chk({tag, " wd"}, wd, e_wd);
    chk({tag, " wel"}, wel, e_wel);
    chk({tag, " rwel"}, rwel, e_rwel);
    chk({tag, " commits"}, n_commit, e_commit);
  endtask

  task automatic unlock();
    logic [2:0] ak;
    wr(8'hB1, 8'hFF, 8'h02, ak); model_ctrl(8'h02, wp);
    wr(8'hB1, 8'hFF, 8'h06, ak); model_ctrl(8'h06, wp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] ak;
    logic k;
    int v0, c0;

    repeat (4) @(negedge clk);
    chk("R13 wd reset", wd, 0);
    chk("R13 wel reset", wel, 0);
    chk("R13 rwel reset", rwel, 0);
    chk("R13 ack reset", sda_low, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: slave byte recognition over every upper nibble
    for (int nib = 0; nib < 16; nib++) begin
      bstart(); sbyte({nib[3:0], 4'b0001}, k); bstop();
      chk($sformatf("R1 ack slave %0h1", nib), k, (nib == 11) ? 1 : 0);
    end
    bstart(); sbyte(8'hA0, k); bstop(); chk("R1 ack A0", k, 1);
    bstart(); sbyte(8'hA2, k); bstop(); chk("R1 ack A2", k, 0);
    // R2: bit-reversed control slave byte is not recognised
    bstart(); sbyte(8'h8D, k); bstop(); chk("R2 msb first 8D", k, 0);

    // R2: acknowledge window
    bstart();
    for (int i = 7; i >= 1; i--) sbit(8'hB1 >> i);
    chk("R2 no ack before 8th fall", sda_low, 0);
    sbit(1'b1);
    m_sda = 1'b1;
    chk("R2 ack after 8th fall", sda_low, 1);
    m_scl = 1'b1; half();
    chk("R2 ack held in 9th clock", sda_low, 1);
    m_scl = 1'b0; half();
    chk("R2 ack released", sda_low, 0);
    bstop();

    // R1: rejected slave ignores rest of transaction
    wr(8'hC1, 8'hFF, 8'h02, ak);
    chk("R1 foreign slave no effect", wel, 0);
    chk("R1 foreign slave no acks", ak, 0);

    // R3: wrong 9-bit addresses
    wr(8'hB0, 8'hFF, 8'h02, ak);
    chk("R3 addr 0FF ignored", wel, 0);
    wr(8'hB1, 8'hFE, 8'h02, ak);
    chk("R3 addr 1FE ignored", wel, 0);

    // R4: 06h without WEL
    wr(8'hB1, 8'hFF, 8'h06, ak); model_ctrl(8'h06, 1'b0);
    chk("R4 rwel needs wel", rwel, 0);

    // R4/R5/R6: sweep third-write data under both protect levels
    for (int d = 0; d < 262; d += ((d < 256) ? 7 : 1)) begin
      logic [7:0] dv;
      dv = (d < 256) ? d[7:0] : ((d == 256) ? 8'h02 : (d == 257) ? 8'h06 :
            (d == 258) ? 8'hC0 : (d == 259) ? 8'h40 : (d == 260) ? 8'h80 : 8'hFF);
      wp = 1'b0;
      unlock();
      chk("R4 wel after 02h", wel, 1);
      chk("R4 rwel after 06h", rwel, 1);
      wp = dv[0] ^ dv[3];
      wr(8'hB3, 8'hFF, dv, ak); model_ctrl(dv, wp);
      cmp_state($sformatf("R5 R6 data %0h wp %0d", dv, wp));
      chk("R7 first data byte acked", ak, 3'b111);
    end
    wp = 1'b0;

    // R7: second data byte ignored, first committed
    unlock();
    bstart(); sbyte(8'hB1, k); sbyte(8'hFF, k); sbyte(8'h80, k);
    sbyte(8'h40, k);
    chk("R7 second data not acked", k, 0);
    bstop(); model_ctrl(8'h80, 1'b0);
    cmp_state("R7 extra byte");

    // R8: no change before stop; repeated start discards
    unlock();
    bstart(); sbyte(8'hB1, k); sbyte(8'hFF, k); sbyte(8'hC0, k);
    chk("R8 wd before stop", wd, e_wd);
    chk("R8 latches before stop", {wel, rwel}, 3);
    bstart(); sbyte(8'hA0, k); sbyte(8'h55, k); sbyte(8'h00, k); bstop();
    cmp_state("R8 repeated start");

    // R9: stop in the middle of a byte aborts
    bstart(); sbyte(8'hB1, k); sbyte(8'hFF, k); sbyte(8'h40, k);
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    bstop();
    cmp_state("R9 mid-byte stop");
    bstart(); sbyte(8'hB1, k); sbyte(8'hFF, k);
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    bstart(); sbyte(8'hB1, k); sbyte(8'hFF, k); sbyte(8'h40, k); bstop();
    model_ctrl(8'h40, 1'b0);
    cmp_state("R9 mid-byte start then valid write");

    // R10/R11/R12: threshold request sweep
    for (int a = 0; a < 8; a++) begin
      for (int dd = 0; dd < 2; dd++) begin
        for (int h = 0; h < 2; h++) begin
          v0 = n_vset; c0 = n_vclr;
          hv = h[0];
          wr(8'hA0, a[7:0], dd[7:0], ak);
          hv = 1'b0;
          chk($sformatf("R10 R12 set a=%0d d=%0d hv=%0d", a, dd, h), n_vset - v0,
              (a == 1 && dd == 0 && h == 1) ? 1 : 0);
          chk($sformatf("R11 R12 clr a=%0d d=%0d hv=%0d", a, dd, h), n_vclr - c0,
              (a == 3 && dd == 0 && h == 1) ? 1 : 0);
        end
      end
    end
    v0 = n_vset;
    hv = 1'b1;
    wr(8'hB0, 8'h01, 8'h00, ak);
    wr(8'hA1, 8'h01, 8'h00, ak);
    hv = 1'b0;
    chk("R10 other slaves no request", n_vset - v0, 0);
    chk("R12 commit count final", n_commit, e_commit);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule